// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of Ethernet PHYs over the two-wire MDC/MDIO bus. The host first programs a configuration register that holds an interface enable and a clock divisor. It can also load a write-data register. It then writes a packed control word that names the PHY, the register inside it and the operation, with an initiate bit set. The block serialises a clause-22 management frame and drives MDC from its own divider. On a read it releases MDIO for the turnaround and the data phase, and it shifts the PHY's answer into the read-data register.

The control word reads back with a ready flag in bit 7, so software can poll for completion. An opcode other than write or read is refused and flagged. A divisor of zero with the interface enabled is reported as a configuration error. MDIO is modelled as separate input, output and output-enable pins, and a board pull-up on MDIO is assumed.

Top module: `mdio_master`

## Requirements
- R1: Control-word fields are: PHY address in bits 28:24, register address in bits 20:16, opcode in bits 15:14 and initiate in bit 11. When the block is idle and the interface is enabled, a control write with initiate set and opcode 1 (write) or 2 (read) starts a frame, and the ready bit (control readback bit 7) reads 0 from the next cycle on.
- R2: A frame is 64 MDC bit times, sent MSB first in this order: 32 ones, start bits 01, opcode bits (01 write, 10 read), 5 PHY address bits, 5 register address bits, 2 turnaround bits, 16 data bits.
- R3: A write frame drives MDIO for all 64 bits, with turnaround 10 and the 16 data bits taken from the write-data register.
- R4: A read frame drives MDIO for bits 0 to 45 only and releases it for the turnaround and data bits. Read data is sampled on each rising MDC edge of bits 48 to 63 and lands in the read-data register when the frame ends.
- R5: A read from a PHY address where no device drives MDIO returns 16'hFFFF.
- R6: MDC toggles every (divisor+1) system clocks, starting low. Ready stays low for exactly 128*(divisor+1) cycles. MDC is low and MDIO is not driven while ready is high. MDIO changes only while MDC is low.
- R7: A control write with initiate set and opcode 0 or 3, made while idle, starts no frame, keeps ready high and sets the invalid-opcode flag. The flag clears when the next frame starts.
- R8: While a frame runs, control writes are ignored: the stored fields do not change and no second frame is queued.
- R9: The configuration register holds an enable in bit 6 and the divisor in bits 5:0. The configuration-error output is high exactly when the enable is set and the divisor is 0.
- R10: With the enable bit clear, an initiate starts no frame. Ready stays high and MDC stays low.
- R11: The write data and the divisor are captured when a frame starts. Changing the write-data register during a frame does not alter the frame on the wire.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the configuration register |
| cfgWrData | input | 7 | Configuration value: enable bit 6, divisor bits 5:0 |
| ctlWrEn | input | 1 | Write strobe for the control word |
| ctlWrData | input | 32 | Control word: PHY, register, opcode, initiate |
| wdWrEn | input | 1 | Write strobe for the write-data register |
| wdWrData | input | 16 | Value for the write-data register |
| mdioIn | input | 1 | MDIO level seen at the pad |
| cfgQ | output | 7 | Configuration register readback |
| ctlQ | output | 32 | Control word readback, with ready in bit 7 |
| rdData | output | 16 | Read-data register |
| opErr | output | 1 | Invalid-opcode flag |
| cfgErr | output | 1 | Enable set with divisor zero |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |

## Verification
The bench builds the block with its defaults: a 32-bit preamble, 5-bit addresses, 16-bit data and a 6-bit divisor, with one modelled PHY at address 5 behind a pull-up. This small setup makes full sweeps affordable. It writes and reads back all 32 registers of that PHY and reads every other PHY address. It sweeps divisors 0 to 5 and checks the exact busy length for each. Every frame is captured bit by bit at the rising MDC edges, together with the drive mask, and compared with a frame the bench assembles from the fields.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DIV_W      = 6;
  localparam int CFG_W      = DIV_W + 1;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_LEN    = 32;
  localparam int FRAME_BITS = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_POS     = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_POS   = TA_POS + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic store;   // latch control word (idle only)
    logic load;    // frame launch
    logic badOp;   // refused opcode
    logic shift;   // advance output frame at MDC fall
    logic sample;  // capture MDIO at MDC rise
    logic commit;  // move captured read data out
  } mdioStrobeT;
endpackage

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic             initBit,
  input  logic [1:0]       opBits,
  input  logic             ifEnable,
  input  logic [DIV_W-1:0] divisor,
  output mdioStrobeT       stb,
  output logic             busy,
  output logic             mdc,
  output logic             busRelease
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic [DIV_W-1:0] divLat;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             rdOp;
  logic             opValid;
  logic             launch;
  logic             tick;
  logic             lastBit;

  always_comb begin
    opValid    = (opBits == 2'b01) || (opBits == 2'b10);
    launch     = !busy && ctlWrEn && initBit && ifEnable && opValid;
    tick       = busy && (divCnt == divLat);
    lastBit    = (bitIdx == LAST_IDX);
    stb.store  = !busy && ctlWrEn;
    stb.load   = launch;
    stb.badOp  = !busy && ctlWrEn && initBit && !opValid;
    stb.shift  = tick && mdc && !lastBit;
    stb.sample = tick && !mdc && rdOp && (bitIdx >= DATA_IDX);
    stb.commit = tick && mdc && lastBit && rdOp;
    busRelease = busy && rdOp && (bitIdx >= TA_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divLat <= '0;
      divCnt <= '0;
      bitIdx <= '0;
      rdOp   <= 1'b0;
    end else if (launch) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divLat <= divisor;
      divCnt <= '0;
      bitIdx <= '0;
      rdOp   <= opBits[1];
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdc    <= !mdc;
        if (mdc) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_shift_dp.sv
module mdio_shift_dp
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobeT        stb,
  input  logic              busy,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [31:0]       ctlWrData,
  input  logic              wdWrEn,
  input  logic [DATA_W-1:0] wdWrData,
  input  logic              mdioIn,
  output logic [CFG_W-1:0]  cfgQ,
  output logic [31:0]       ctlQ,
  output logic [DATA_W-1:0] rdData,
  output logic              opErr,
  output logic              cfgErr,
  output logic              ifEnable,
  output logic [DIV_W-1:0]  divisor,
  output logic              mdioOut
);
  logic [CFG_W-1:0]      cfgReg;
  logic [31:0]           ctlReg;
  logic [DATA_W-1:0]     wdReg;
  logic [DATA_W-1:0]     rxSh;
  logic [FRAME_BITS-1:0] frameSh;
  logic                  isRd;

  assign isRd     = ctlWrData[15];
  assign ifEnable = cfgReg[DIV_W];
  assign divisor  = cfgReg[DIV_W-1:0];
  assign cfgErr   = ifEnable && (divisor == '0);
  assign cfgQ     = cfgReg;
  assign ctlQ     = {ctlReg[31:8], !busy, ctlReg[6:0]};
  assign mdioOut  = frameSh[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= '0;
      ctlReg  <= '0;
      wdReg   <= '0;
      rxSh    <= '0;
      rdData  <= '0;
      frameSh <= '0;
      opErr   <= 1'b0;
    end else begin
      if (cfgWrEn) cfgReg <= cfgWrData;
      if (wdWrEn)  wdReg  <= wdWrData;
      if (stb.store) ctlReg <= ctlWrData;
      if (stb.badOp) opErr <= 1'b1;
      else if (stb.load) opErr <= 1'b0;
      if (stb.load) begin
        frameSh <= {{PRE_LEN{1'b1}}, 2'b01, ctlWrData[15:14],
                    ctlWrData[28:24], ctlWrData[20:16],
                    isRd ? 2'b00 : 2'b10,
                    isRd ? {DATA_W{1'b0}} : wdReg};
      end else if (stb.shift) begin
        frameSh <= {frameSh[FRAME_BITS-2:0], 1'b1};
      end
      if (stb.sample) rxSh <= {rxSh[DATA_W-2:0], mdioIn};
      if (stb.commit) rdData <= rxSh;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              ctlWrEn,
  input  logic [31:0]       ctlWrData,
  input  logic              wdWrEn,
  input  logic [DATA_W-1:0] wdWrData,
  input  logic              mdioIn,
  output logic [CFG_W-1:0]  cfgQ,
  output logic [31:0]       ctlQ,
  output logic [DATA_W-1:0] rdData,
  output logic              opErr,
  output logic              cfgErr,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe
);
  mdioStrobeT       stb;
  logic             busy;
  logic             busRelease;
  logic             ifEnable;
  logic [DIV_W-1:0] divisor;

  mdio_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctlWrEn    (ctlWrEn),
    .initBit    (ctlWrData[11]),
    .opBits     (ctlWrData[15:14]),
    .ifEnable   (ifEnable),
    .divisor    (divisor),
    .stb        (stb),
    .busy       (busy),
    .mdc        (mdc),
    .busRelease (busRelease)
  );

  mdio_shift_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busy      (busy),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .ctlWrData (ctlWrData),
    .wdWrEn    (wdWrEn),
    .wdWrData  (wdWrData),
    .mdioIn    (mdioIn),
    .cfgQ      (cfgQ),
    .ctlQ      (ctlQ),
    .rdData    (rdData),
    .opErr     (opErr),
    .cfgErr    (cfgErr),
    .ifEnable  (ifEnable),
    .divisor   (divisor),
    .mdioOut   (mdioOut)
  );

  assign mdioOe = busy && !busRelease;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mdc,
  input logic        mdioOe,
  input logic        mdioOut,
  input logic [31:0] ctlQ,
  input logic        ctlWrEn,
  input logic        initBit,
  input logic [1:0]  opBits,
  input logic        enBit,
  input logic        opErr
);
  // R6: idle bus is quiet
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctlQ[7] |-> (!mdc && !mdioOe));

  // R6: output only moves while MDC is low
  assert_mdio_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));

  // R1: accepted initiate drops ready
  assert_ready_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctlQ[7] && ctlWrEn && initBit && enBit && (opBits == 2'b01 || opBits == 2'b10))
    |=> !ctlQ[7]);

  // R7: refused opcode keeps ready and raises the flag
  assert_bad_op_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlQ[7] && ctlWrEn && initBit && (opBits == 2'b00 || opBits == 2'b11))
    |=> (ctlQ[7] && opErr));

  // R8: control writes during a frame leave stored fields alone
  assert_busy_lock_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlQ[7] && ctlWrEn) |=> ($stable(ctlQ[31:8]) && $stable(ctlQ[6:0])));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mdc     (mdc),
  .mdioOe  (mdioOe),
  .mdioOut (mdioOut),
  .ctlQ    (ctlQ),
  .ctlWrEn (ctlWrEn),
  .initBit (ctlWrData[11]),
  .opBits  (ctlWrData[15:14]),
  .enBit   (cfgQ[6]),
  .opErr   (opErr)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  import mdio_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int PHY_ADDR   = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [6:0]  cfgWrData = '0;
  logic        ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic        wdWrEn = 1'b0;
  logic [15:0] wdWrData = '0;
  logic        mdioIn;
  logic [6:0]  cfgQ;
  logic [31:0] ctlQ;
  logic [15:0] rdData;
  logic        opErr, cfgErr, mdc, mdioOut, mdioOe;

  int checks = 0;
  int fails = 0;
  int fallCnt = 0;
  logic        phyAct = 1'b0;
  logic [15:0] respData = '0;
  logic [63:0] capIn = '0;
  logic [63:0] capOe = '0;
  logic [15:0] phyRegs [32];

  mdio_master dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model with pull-up: drives read data only when addressed
  assign mdioIn = mdioOe ? mdioOut :
                  ((phyAct && fallCnt >= DATA_POS && fallCnt < FRAME_BITS) ?
                   respData[FRAME_BITS-1-fallCnt] : 1'b1);

  always @(negedge mdc) fallCnt = fallCnt + 1;
  always @(posedge mdc) begin
    if (fallCnt < 64) begin
      capIn[63-fallCnt] = mdioIn;
      capOe[63-fallCnt] = mdioOe;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlWord(input logic [1:0] op, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic ini);
    return {3'b0, phy, 3'b0, rg, op, 2'b0, ini, 11'h0};
  endfunction

  task automatic setCfg(input logic [6:0] v);
    @(negedge clk) cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk) cfgWrEn = 1'b0;
  endtask

  task automatic xfer(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] wdata, input int div, input bit disturb);
    logic [63:0] expFrame, expOe;
    logic [15:0] expData;
    logic [31:0] word;
    int cyc;
    expData  = (phy == PHY_ADDR) ? phyRegs[rg] : 16'hFFFF;
    respData = phyRegs[rg];
    phyAct   = (phy == PHY_ADDR) && (op == 2'b10);
    @(negedge clk) wdWrEn = 1'b1; wdWrData = wdata;
    @(negedge clk) wdWrEn = 1'b0;
    fallCnt = 0; capIn = '0; capOe = '0;
    word = ctlWord(op, phy, rg, 1'b1);
    ctlWrEn = 1'b1; ctlWrData = word;
    @(negedge clk) ctlWrEn = 1'b0;
    check("R1 ready low after initiate", {63'b0, ctlQ[7]}, 64'd0);
    cyc = 1;
    while (!ctlQ[7] && cyc < 100000) begin
      if (disturb && cyc == 20) begin
        ctlWrEn = 1'b1; ctlWrData = ctlWord(2'b10, 5'd9, 5'd3, 1'b1);
        wdWrEn = 1'b1; wdWrData = ~wdata;
      end else begin
        ctlWrEn = 1'b0; wdWrEn = 1'b0;
      end
      @(negedge clk);
      if (!ctlQ[7]) cyc++;
    end
    ctlWrEn = 1'b0; wdWrEn = 1'b0;
    check("R6 busy length", 64'(cyc), 64'(128 * (div + 1)));
    if (op == 2'b10) begin
      expFrame = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b11, expData};
      expOe    = ~64'h3FFFF;
      check("R2 R4 read frame on wire", capIn, expFrame);
      check("R4 read drive mask", capOe, expOe);
      check(phy == PHY_ADDR ? "R4 read data" : "R5 absent PHY reads ones",
            64'(rdData), 64'(expData));
    end else begin
      expFrame = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, wdata};
      check(disturb ? "R11 R3 write frame kept" : "R2 R3 write frame on wire", capIn, expFrame);
      check("R3 write drive mask", capOe, ~64'h0);
      if (phy == PHY_ADDR) phyRegs[rg] = wdata;
    end
    check(disturb ? "R8 fields kept after busy write" : "R1 control readback",
          64'(ctlQ), 64'(word | 32'h80));
    phyAct = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) phyRegs[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset ctlQ ready", 64'(ctlQ), 64'h80);
    check("R4 reset rdData", 64'(rdData), 64'h0);
    check("R9 reset cfgQ", 64'(cfgQ), 64'h0);
    check("R6 reset mdc/oe", {62'b0, mdc, mdioOe}, 64'h0);
    check("R7 reset opErr", {63'b0, opErr}, 64'h0);

    // R9 configuration fields and error
    setCfg(7'h40);
    check("R9 cfg readback", 64'(cfgQ), 64'h40);
    check("R9 cfgErr with zero divisor", {63'b0, cfgErr}, 64'h1);
    setCfg(7'h01);
    check("R9 cfgErr when disabled", {63'b0, cfgErr}, 64'h0);

    // R10 disabled interface ignores initiate
    @(negedge clk) ctlWrEn = 1'b1; ctlWrData = ctlWord(2'b10, 5'd5, 5'd1, 1'b1);
    @(negedge clk) ctlWrEn = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 disabled stays ready", {63'b0, ctlQ[7]}, 64'h1);
    check("R10 disabled no mdc", {62'b0, mdc, mdioOe}, 64'h0);

    setCfg(7'h41);
    check("R9 cfgErr clear", {63'b0, cfgErr}, 64'h0);

    // R3 writes to every register of the modelled PHY
    for (int r = 0; r < 32; r++)
      xfer(2'b01, 5'(PHY_ADDR), 5'(r), 16'(r * 2341) ^ 16'hA5C3, 1, 1'b0);
    // R4 read back every register
    for (int r = 0; r < 32; r++)
      xfer(2'b10, 5'(PHY_ADDR), 5'(r), 16'h0, 1, 1'b0);
    // R5 every other PHY address is absent
    for (int a = 0; a < 32; a++)
      if (a != PHY_ADDR) xfer(2'b10, 5'(a), 5'(a), 16'h0, 1, 1'b0);

    // R7 refused opcodes
    for (int op = 0; op < 4; op += 3) begin
      @(negedge clk) ctlWrEn = 1'b1; ctlWrData = ctlWord(2'(op), 5'd5, 5'd2, 1'b1);
      @(negedge clk) ctlWrEn = 1'b0;
      check("R7 bad op keeps ready", {63'b0, ctlQ[7]}, 64'h1);
      check("R7 bad op flagged", {63'b0, opErr}, 64'h1);
      repeat (4) @(negedge clk);
      check("R7 bad op no mdc", {63'b0, mdc}, 64'h0);
    end
    xfer(2'b10, 5'(PHY_ADDR), 5'd2, 16'h0, 1, 1'b0);
    check("R7 flag cleared by new frame", {63'b0, opErr}, 64'h0);

    // R8 R11 writes while busy
    xfer(2'b01, 5'(PHY_ADDR), 5'd7, 16'h3C5A, 1, 1'b1);
    xfer(2'b10, 5'(PHY_ADDR), 5'd7, 16'h0, 1, 1'b0);

    // R6 divisor sweep
    for (int d = 0; d < 6; d++) begin
      setCfg(7'h40 | 7'(d));
      check("R9 cfgErr in sweep", {63'b0, cfgErr}, 64'(d == 0));
      xfer(2'b01, 5'(PHY_ADDR), 5'(d + 10), 16'(d * 4099 + 77), d, 1'b0);
      xfer(2'b10, 5'(PHY_ADDR), 5'(d + 10), 16'h0, d, 1'b0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule